// File: doc/BRIEF.md
# Staged Switch Command Decoder

This block sits behind a serial control port and turns 16-bit command words into the gate enables of five two-input analog multiplexers and one general-purpose logic output. Each word carries a command byte in its upper half and a control byte in its lower half. The command is decoded into per-switch open and close requests, which are merged into a pending copy of the switch and output state. The live outputs are not disturbed until a word arrives with its load bit set. That word's own command is merged as well, and the whole pending state is transferred to the live outputs in one clock edge.

Two safety properties are kept in hardware. No multiplexer ever has both of its sides closed. A multiplexer that changes from one side to the other is held open for one cycle before the new side closes. A reset bit in every word lets software return the block to its idle state without touching the hardware reset. A 16-bit status word mirrors the live outputs for readback.

Top module: `stg_switch_top`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, all ten switch enables, `gpoLevel` and `statusWord` are 0. The pending state is also cleared by `rstN`.
- R2: A word is taken only in a cycle with `wordValid` high. Bit 15 is the close/open flag, bits 14:8 are the command code, bit 0 is the load bit and bit 1 is the keep bit. A valid word with keep=1 and load=0 leaves every output unchanged.
- R3: A valid word with keep=1 and load=1 merges its own command with all staged commands. The live outputs show the result after the clock edge that samples the word. Back-to-back words in consecutive cycles are all taken.
- R4: Code 0x00 closes (flag 1) or opens (flag 0) the A side of every multiplexer. Code 0x01 does the same for every B side.
- R5: Codes 0x02 to 0x0B each address one switch. In order they are mux1 A, mux1 B, mux2 A, mux2 B, and so on up to mux5 B. The flag selects close (1) or open (0).
- R6: Codes 0x0E to 0x12 open both sides of mux 1 to mux 5 respectively, whatever the flag. Code 0x1F with the flag clear opens every switch.
- R7: Code 0x14 sets the pending output level to the flag value.
- R8: Every other code, and 0x1F with the flag set, changes neither the pending nor the live state.
- R9: Among staged commands, the last one touching a switch or the output decides its value. Closing one side of a multiplexer also opens its other side in the pending state.
- R10: Both sides of one multiplexer are never closed together. On a load that moves a multiplexer from one side to the other, that multiplexer shows both sides open for the first cycle, and the new side closes one cycle later.
- R11: A valid word with keep=0 opens every switch and drives `gpoLevel` low from the next cycle. It also clears the pending state, and its own command is ignored.
- R12: `statusWord` bit 15-i equals `swEnable[i]` for i = 0..9, with `swEnable` index 2*(mux-1) for the A side and 2*(mux-1)+1 for the B side. Bit 3 equals `gpoLevel`. All other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| wordValid | input | 1 | Marks `wordData` as a command word for this cycle |
| wordData | input | 16 | Command byte in bits 15:8, control byte in bits 7:0 |
| swEnable | output | 10 | Live switch enables, A/B pairs for mux 1 to 5 |
| gpoLevel | output | 1 | Live general-purpose output level |
| statusWord | output | 16 | Readback image of the live outputs |

## Verification
A load or keep-clear word takes effect at the same rising edge that samples it. The bench drives each word for one cycle from a falling edge and compares all three outputs at the next falling edge. Multiplexers that change side are due one cycle later, so each word is followed by a second comparison one falling edge further on. At the first sample those multiplexers are expected fully open, and at the second they are expected at their final value. Staged words are compared at both samples against the unchanged previous outputs. A reference model in the bench, built from the code table, drives a sweep of every command byte from two different starting states.

// File: rtl/stg_pkg.sv
package stg_pkg;
  localparam int MUX_COUNT = 5;
  localparam int SW_COUNT  = 2 * MUX_COUNT;
  localparam int WORD_W    = 16;
  localparam int CODE_W    = 7;
  localparam int STAT_W    = 16;

  // strobes from the decoder to the state datapath
  typedef struct packed {
    logic                valid;
    logic                keepN;   // 0 = clear everything
    logic                commit;
    logic [SW_COUNT-1:0] swOn;
    logic [SW_COUNT-1:0] swOff;
    logic                gpoWr;
    logic                gpoVal;
  } cmdStrobes_t;
endpackage

// File: rtl/stg_cmd_decode.sv
module stg_cmd_decode
  import stg_pkg::*;
#(
  parameter int ON_BIT       = 15,
  parameter int CODE_LSB     = 8,
  parameter int LOAD_BIT     = 0,
  parameter int KEEP_BIT     = 1,
  parameter int IND_BASE     = 2,
  parameter int DIS_BASE     = 14,
  parameter int GPO_CODE     = 20,
  parameter int ALL_OFF_CODE = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output cmdStrobes_t       strb
);
  localparam int CODE_MSB = CODE_LSB + CODE_W - 1;

  logic              cmdOn;
  logic [CODE_W-1:0] code;
  logic              allOff;

  assign cmdOn  = wordData[ON_BIT];
  assign code   = wordData[CODE_MSB:CODE_LSB];
  assign allOff = (code == CODE_W'(ALL_OFF_CODE)) && !cmdOn;

  assign strb.valid  = wordValid;
  assign strb.keepN  = wordData[KEEP_BIT];
  assign strb.commit = wordData[LOAD_BIT];
  assign strb.gpoWr  = wordValid && (code == CODE_W'(GPO_CODE));
  assign strb.gpoVal = cmdOn;

  for (genvar m = 0; m < MUX_COUNT; m++) begin : g_mux
    logic disHit;
    assign disHit = (code == CODE_W'(DIS_BASE + m)) || allOff;
    for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int IDX = 2 * m + s;
      logic hit;
      assign hit = (code == CODE_W'(s)) || (code == CODE_W'(IND_BASE + IDX));
      assign strb.swOn[IDX]  = wordValid && cmdOn && hit;
      assign strb.swOff[IDX] = wordValid && ((!cmdOn && hit) || disHit);
    end

    // R10
    side_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.swOn[2*m] && strb.swOn[2*m+1]));
  end

  // R8
  reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && (((code > 7'd11) && (code < 7'd14)) || (code == 7'd19) ||
     ((code > 7'd20) && (code != 7'd31)) || ((code == 7'd31) && cmdOn)))
    |-> (strb.swOn == '0 && strb.swOff == '0 && !strb.gpoWr));

  // R6
  disable_no_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && (code >= 7'd14) && (code <= 7'd18)) |-> (strb.swOn == '0));
endmodule

// File: rtl/stg_switch_state.sv
module stg_switch_state
  import stg_pkg::*;
#(
  parameter int STAT_SW_TOP  = 15,
  parameter int STAT_GPO_BIT = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  cmdStrobes_t         strb,
  output logic [SW_COUNT-1:0] liveSw,
  output logic                liveGpo,
  output logic [STAT_W-1:0]   statusWord
);
  logic [SW_COUNT-1:0]  pendSw, pendNext, deferSw, loadSw, deferNext;
  logic                 pendGpo, gpoNext;
  logic [MUX_COUNT-1:0] overMask;
  logic                 clearAll, doLoad;

  assign clearAll = strb.valid && !strb.keepN;
  assign doLoad   = strb.valid && strb.keepN && strb.commit;

  // merge this word into the pending image, then split switch-overs
  always_comb begin
    pendNext = pendSw;
    for (int m = 0; m < MUX_COUNT; m++) begin
      if (strb.swOff[2*m])   pendNext[2*m]   = 1'b0;
      if (strb.swOff[2*m+1]) pendNext[2*m+1] = 1'b0;
      if (strb.swOn[2*m]) begin
        pendNext[2*m]   = 1'b1;
        pendNext[2*m+1] = 1'b0;
      end
      if (strb.swOn[2*m+1]) begin
        pendNext[2*m+1] = 1'b1;
        pendNext[2*m]   = 1'b0;
      end
    end
    gpoNext = strb.gpoWr ? strb.gpoVal : pendGpo;
    for (int m = 0; m < MUX_COUNT; m++) begin
      overMask[m] = (pendNext[2*m] && liveSw[2*m+1]) ||
                    (pendNext[2*m+1] && liveSw[2*m]);
      loadSw[2*m]      = pendNext[2*m]   && !overMask[m];
      loadSw[2*m+1]    = pendNext[2*m+1] && !overMask[m];
      deferNext[2*m]   = pendNext[2*m]   && overMask[m];
      deferNext[2*m+1] = pendNext[2*m+1] && overMask[m];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clearAll) begin
      pendSw  <= '0;
      pendGpo <= 1'b0;
      liveSw  <= '0;
      liveGpo <= 1'b0;
      deferSw <= '0;
    end else begin
      if (strb.valid) begin
        pendSw  <= pendNext;
        pendGpo <= gpoNext;
      end
      if (doLoad) begin
        liveSw  <= loadSw;
        liveGpo <= gpoNext;
        deferSw <= deferNext;
      end else if (deferSw != '0) begin
        liveSw  <= liveSw | deferSw;
        deferSw <= '0;
      end
    end
  end

  always_comb begin
    statusWord = '0;
    for (int i = 0; i < SW_COUNT; i++) statusWord[STAT_SW_TOP-i] = liveSw[i];
    statusWord[STAT_GPO_BIT] = liveGpo;
  end

  for (genvar m = 0; m < MUX_COUNT; m++) begin : g_chk
    // R10
    pair_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(liveSw[2*m] && liveSw[2*m+1]));
    // R10
    bbm_a_chk: assert property (@(posedge clk) disable iff (!rstN)
      liveSw[2*m] |=> !liveSw[2*m+1]);
    // R10
    bbm_b_chk: assert property (@(posedge clk) disable iff (!rstN)
      liveSw[2*m+1] |=> !liveSw[2*m]);
  end

  // R11
  reset_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.valid && !strb.keepN) |=> (liveSw == '0 && !liveGpo));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(strb.valid && strb.commit) && !(strb.valid && !strb.keepN) && deferSw == '0)
    |=> ($stable(liveSw) && $stable(liveGpo)));

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    !rstN |=> (liveSw == '0 && !liveGpo && pendSw == '0));
endmodule

// File: rtl/stg_switch_top.sv
module stg_switch_top
  import stg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic [SW_COUNT-1:0] swEnable,
  output logic              gpoLevel,
  output logic [STAT_W-1:0] statusWord
);
  cmdStrobes_t strb;

  stg_cmd_decode u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .wordValid (wordValid),
    .wordData  (wordData),
    .strb      (strb)
  );

  stg_switch_state u_state (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .liveSw     (swEnable),
    .liveGpo    (gpoLevel),
    .statusWord (statusWord)
  );
endmodule

// File: tb/stg_switch_top_tb_top.sv
`timescale 1ns/1ps
module stg_switch_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [15:0] wordData = '0;
  logic [9:0]  swEnable;
  logic        gpoLevel;
  logic [15:0] statusWord;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [9:0] refPend = '0;
  logic [9:0] refLive = '0;
  logic       refPg   = 1'b0;
  logic       refGpo  = 1'b0;

  always #4 clk = ~clk;

  stg_switch_top dut_i (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .swEnable(swEnable), .gpoLevel(gpoLevel), .statusWord(statusWord)
  );

  // reference: {gpo, sw[9:0]} after one command byte
  function automatic logic [10:0] applyCmd(input logic [10:0] st, input logic [7:0] cmd);
    logic [10:0] r;
    int c;
    logic b;
    int idx;
    r = st;
    c = int'(cmd[6:0]);
    b = cmd[7];
    if (c < 2) begin
      for (int m = 0; m < 5; m++) begin
        r[2*m+c] = b;
        if (b) r[2*m+1-c] = 1'b0;
      end
    end else if (c <= 11) begin
      idx = c - 2;
      r[idx] = b;
      if (b) r[idx ^ 1] = 1'b0;
    end else if (c >= 14 && c <= 18) begin
      r[2*(c-14)]   = 1'b0;
      r[2*(c-14)+1] = 1'b0;
    end else if (c == 20) begin
      r[10] = b;
    end else if (c == 31 && !b) begin
      r[9:0] = '0;
    end
    return r;
  endfunction

  function automatic logic [15:0] statusOf(input logic [9:0] sw, input logic g);
    logic [15:0] s;
    s = '0;
    for (int i = 0; i < 10; i++) s[15-i] = sw[i];
    s[3] = g;
    return s;
  endfunction

  function automatic string reqOf(input logic [7:0] cmd);
    int c;
    c = int'(cmd[6:0]);
    if (c < 2) return "R4";
    if (c <= 11) return "R5";
    if ((c >= 14 && c <= 18) || (c == 31 && !cmd[7])) return "R6";
    if (c == 20) return "R7";
    return "R8";
  endfunction

  task automatic checkOut(input logic [9:0] sw, input logic g, input string tag, input string what);
    logic [26:0] expV;
    logic [26:0] actV;
    expV = {statusOf(sw, g), sw, g};
    actV = {statusWord, swEnable, gpoLevel};
    checks++;
    if (actV !== expV) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, actV, expV);
    end
  endtask

  // drive one word, model it, check the first and second cycle after it
  task automatic doWord(input logic [15:0] w, input string tag);
    logic [10:0] nxt;
    logic [9:0]  mid;
    if (!w[1]) begin
      refPend = '0; refPg = 1'b0; refLive = '0; refGpo = 1'b0;
      mid = '0;
    end else begin
      nxt = applyCmd({refPg, refPend}, w[15:8]);
      refPend = nxt[9:0];
      refPg   = nxt[10];
      if (w[0]) begin
        for (int m = 0; m < 5; m++) begin
          if ((nxt[2*m] && refLive[2*m+1]) || (nxt[2*m+1] && refLive[2*m])) begin
            mid[2*m] = 1'b0; mid[2*m+1] = 1'b0;
          end else begin
            mid[2*m] = nxt[2*m]; mid[2*m+1] = nxt[2*m+1];
          end
        end
        refLive = nxt[9:0];
        refGpo  = nxt[10];
      end else begin
        mid = refLive;
      end
    end
    @(negedge clk);
    wordValid = 1'b1;
    wordData  = w;
    @(negedge clk);
    wordValid = 1'b0;
    wordData  = '0;
    checkOut(mid, refGpo, tag, $sformatf("word %h first cycle", w));
    @(negedge clk);
    checkOut(refLive, refGpo, tag, $sformatf("word %h second cycle", w));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [10:0] nx;
    repeat (4) @(negedge clk);
    checkOut('0, 1'b0, "R1", "during reset");
    rstN = 1'b1;
    @(negedge clk);
    checkOut('0, 1'b0, "R1", "after reset");

    // staging, last write wins, load of staged state (R2 R9 R3)
    doWord(16'h8202, "R2");       // mux1 A close, staged
    doWord(16'h8302, "R9");       // mux1 B close, staged
    doWord(16'h9402, "R2");       // output high, staged
    doWord(16'h0D02, "R2");       // reserved, staged
    doWord(16'h7F03, "R3");       // reserved + load: mux1 B and output live
    // switch-over on load
    doWord(16'h8203, "R10");      // mux1 B -> A
    doWord(16'h8103, "R10");      // all B close: every mux that had A swaps
    doWord(16'h8003, "R10");      // all A close
    // reset frame clears pending too
    doWord(16'h8502, "R11");      // stage mux2 B
    doWord(16'h8601, "R11");      // keep low with a close command
    doWord(16'h7F03, "R11");      // load: nothing staged survives

    // back-to-back words (R3)
    nx = applyCmd({refPg, refPend}, 8'h88);
    nx = applyCmd(nx, 8'h94);
    refPend = nx[9:0]; refPg = nx[10]; refLive = nx[9:0]; refGpo = nx[10];
    @(negedge clk);
    wordValid = 1'b1; wordData = 16'h8802;
    @(negedge clk);
    wordData = 16'h9403;
    @(negedge clk);
    wordValid = 1'b0; wordData = '0;
    checkOut(refLive, refGpo, "R3", "back-to-back load");
    @(negedge clk);

    // hardware reset mid-run clears live and pending (R1)
    doWord(16'h8B02, "R1");
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    refPend = '0; refPg = 1'b0; refLive = '0; refGpo = 1'b0;
    checkOut('0, 1'b0, "R1", "mid-run reset");
    rstN = 1'b1;
    doWord(16'h7F03, "R1");

    // status mapping on a mixed pattern (R12)
    doWord(16'h8302, "R12");
    doWord(16'h8602, "R12");
    doWord(16'h8B02, "R12");
    doWord(16'h9403, "R12");

    // sweep every command byte from two starting states
    for (int base = 0; base < 2; base++) begin
      for (int cb = 0; cb < 256; cb++) begin
        doWord(16'h0001, "R11");
        if (base == 0) begin
          doWord(16'h8003, "R4");
        end else begin
          doWord(16'h8302, "R9");
          doWord(16'h8602, "R9");
          doWord(16'h8B02, "R9");
          doWord(16'h9403, "R7");
        end
        doWord({cb[7:0], 8'h03}, reqOf(cb[7:0]));
        doWord({cb[7:0], 8'h02}, "R2");
        doWord(16'h7F03, reqOf(cb[7:0]));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule